// File: doc/BRIEF.md
# Tamper Event Timestamp Capture

This unit sits beside a calendar core and watches a tamper event line. When timestamp-on-tamper is switched on and an event pulse arrives, the unit copies the live time word and a trimmed copy of the live date word into two holding registers. It also raises a "stamp taken" flag. If a further event arrives before software has cleared that flag, the unit raises an overflow flag instead and keeps the first capture.

Software clears the flags by writing ones to a clear register. A protection bit, which only secure bus masters may write, decides whether non-secure masters may see and touch the timestamp resources. Under protection, those resources read as zero to a non-secure master and ignore its writes. The bus is a single-cycle register port: a write takes effect at the clock edge, and read data is combinational from the selected register.

Top module: `tsc_top`

## Requirements
- R1: After reset every register reads zero: the control word at 0x18, the protection word at 0x20, the time stamp at 0x30, the date stamp at 0x34 and the status at 0x50. Because protection bit 3 is zero, access starts out secure-only.
- R2: While bit 25 of the control word at 0x18 is zero, a tamper pulse changes neither the stamps nor the status.
- R3: With bit 25 set and status bit 3 clear, a tamper pulse in one cycle loads the time stamp with the live time masked to 0x007F7F7F and sets status bit 3. Both changes are visible after that clock edge.
- R4: The date stamp keeps only bits [5:0] (day), [12:8] (month) and [15:13] (weekday) of the live date, which is the mask 0x0000FF3F. The year bits and all other bits read zero.
- R5: A tamper pulse that arrives while status bit 3 is set sets status bit 4 (overflow) and leaves both stamps unchanged.
- R6: Writing to the clear register at 0x5C clears status bit 3 if wdata bit 3 is one, and clears status bit 4 if wdata bit 4 is one. A zero bit leaves its flag unchanged.
- R7: If a tamper pulse and a write-one clear of bit 3 fall in the same cycle, status bit 3 remains set afterwards.
- R8: While bit 3 of the protection word at 0x20 is zero, a non-secure master reads zero from 0x18, 0x30, 0x34, 0x50 and 0x5C, and its writes to 0x18 and 0x5C are ignored.
- R9: Only a secure write changes the protection word at 0x20. Once its bit 3 is one, a non-secure master reads and clears the timestamp resources like a secure one.
- R10: Reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| live_time_i | input | 32 | Current time word from the calendar core |
| live_date_i | input | 32 | Current date word from the calendar core |
| tamper_i | input | 1 | Tamper event pulse, one cycle per event |
| bus_sel_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_secure_i | input | 1 | Secure attribute of the access |
| bus_rdata_o | output | 32 | Read data, combinational |

## Verification
A sweep of eight different live time and date words, including ones with year and filler bits set, shows that the stamps come from the first event and that the date mask trims the right bits. Each sweep step follows the first event with a second one carrying different values. This separates the capture path from the overflow path, which must leave the stamps alone. Each step then clears the flags with all-zero, bit-3-only and bit-4-only patterns, which shows that each clear bit acts only on its own flag. Coincident event-and-clear cycles, tried with the flag already set and with it clear, show the priority between the two. Non-secure reads and writes, made before and after the protection bit is opened, show the access gate at work.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
    localparam int WORD_W = 32;

    localparam int OFS_CTRL = 'h18;
    localparam int OFS_PROT = 'h20;
    localparam int OFS_TIME = 'h30;
    localparam int OFS_DATE = 'h34;
    localparam int OFS_STAT = 'h50;
    localparam int OFS_CLR  = 'h5C;

    localparam int CTRL_EN_BIT   = 25;
    localparam int PROT_OPEN_BIT = 3;
    localparam int ST_FLAG_BIT   = 3;
    localparam int ST_OVF_BIT    = 4;

    localparam logic [WORD_W-1:0] TIME_KEEP = 32'h007F_7F7F;
    localparam logic [WORD_W-1:0] DATE_KEEP = 32'h0000_FF3F;

    typedef enum logic [2:0] {
        RS_NONE, RS_CTRL, RS_PROT, RS_TIME, RS_DATE, RS_STAT
    } rsel_t;

    typedef struct packed {
        logic [WORD_W-1:0] tm;
        logic [WORD_W-1:0] dt;
        logic              flag;
        logic              ovf;
    } stamp_t;

    typedef struct packed {
        logic en;
        logic open;
    } cfg_t;
endpackage

// File: rtl/tsc_bus_decode.sv
module tsc_bus_decode
    import tsc_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              sel_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              secure_i,
    input  logic              open_i,
    output logic              wr_ctrl_o,
    output logic              wr_prot_o,
    output logic              wr_clr_o,
    output rsel_t             rsel_o
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_PROT = ADDR_W'(OFS_PROT);
    localparam logic [ADDR_W-1:0] A_TIME = ADDR_W'(OFS_TIME);
    localparam logic [ADDR_W-1:0] A_DATE = ADDR_W'(OFS_DATE);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFS_CLR);

    logic guarded;
    logic permit;

    always_comb begin
        guarded = (addr_i == A_CTRL) || (addr_i == A_TIME) || (addr_i == A_DATE)
               || (addr_i == A_STAT) || (addr_i == A_CLR);
        permit  = secure_i || open_i;

        wr_ctrl_o = sel_i && wr_i && (addr_i == A_CTRL) && permit;
        wr_clr_o  = sel_i && wr_i && (addr_i == A_CLR)  && permit;
        wr_prot_o = sel_i && wr_i && (addr_i == A_PROT) && secure_i;

        rsel_o = RS_NONE;
        if (sel_i && !wr_i && (!guarded || permit)) begin
            case (addr_i)
                A_CTRL:  rsel_o = RS_CTRL;
                A_PROT:  rsel_o = RS_PROT;
                A_TIME:  rsel_o = RS_TIME;
                A_DATE:  rsel_o = RS_DATE;
                A_STAT:  rsel_o = RS_STAT;
                default: rsel_o = RS_NONE;
            endcase
        end
    end
endmodule

// File: rtl/tsc_cfg.sv
module tsc_cfg
    import tsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl_i,
    input  logic              wr_prot_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic              en_o,
    output logic              open_o
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_ctrl_i) cfg_d.en   = wdata_i[CTRL_EN_BIT];
        if (wr_prot_i) cfg_d.open = wdata_i[PROT_OPEN_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign en_o   = cfg_q.en;
    assign open_o = cfg_q.open;

    // R9: protection word moves only on a secure write
    a_r9_prot_only_by_secure: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_prot_i |=> $stable(cfg_q.open));
endmodule

// File: rtl/tsc_capture.sv
module tsc_capture
    import tsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              tamper_i,
    input  logic [WORD_W-1:0] time_i,
    input  logic [WORD_W-1:0] date_i,
    input  logic              clr_wr_i,
    input  logic [WORD_W-1:0] clr_data_i,
    output logic [WORD_W-1:0] stamp_time_o,
    output logic [WORD_W-1:0] stamp_date_o,
    output logic              flag_o,
    output logic              ovf_o
);
    stamp_t st_d, st_q;
    logic   event_now;
    logic   clr_flag;
    logic   clr_ovf;

    always_comb begin
        event_now = tamper_i && en_i;
        clr_flag  = clr_wr_i && clr_data_i[ST_FLAG_BIT];
        clr_ovf   = clr_wr_i && clr_data_i[ST_OVF_BIT];

        st_d = st_q;
        if (event_now && !st_q.flag) begin
            st_d.tm = time_i & TIME_KEEP;
            st_d.dt = date_i & DATE_KEEP;
        end
        st_d.flag = event_now || (st_q.flag && !clr_flag);
        st_d.ovf  = (event_now && st_q.flag) || (st_q.ovf && !clr_ovf);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stamp_time_o = st_q.tm;
    assign stamp_date_o = st_q.dt;
    assign flag_o       = st_q.flag;
    assign ovf_o        = st_q.ovf;

    // R2: disabled capture leaves stamps alone and raises no flag
    a_r2_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !clr_wr_i) |=> ($stable(st_q.tm) && $stable(st_q.dt) && $stable(st_q.flag)));

    // R3: first event captures the live time and sets the flag
    a_r3_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (tamper_i && en_i && !st_q.flag) |=> (st_q.flag && st_q.tm == ($past(time_i) & TIME_KEEP)));

    // R4: date stamp never holds bits outside the kept fields
    a_r4_date_trim: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.dt & ~DATE_KEEP) == '0);

    // R5: event on a set flag raises overflow and keeps the stamps
    a_r5_overflow_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (tamper_i && en_i && st_q.flag) |=> (st_q.ovf && $stable(st_q.tm) && $stable(st_q.dt)));

    // R6: a clear with no event drops the flag
    a_r6_clear_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr_i && clr_data_i[ST_FLAG_BIT] && !(tamper_i && en_i)) |=> !st_q.flag);

    // R7: coincident event beats the clear
    a_r7_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (tamper_i && en_i && clr_wr_i) |=> st_q.flag);
endmodule

// File: rtl/tsc_top.sv
module tsc_top
    import tsc_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       live_time_i,
    input  logic [31:0]       live_date_i,
    input  logic              tamper_i,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    input  logic              bus_secure_i,
    output logic [31:0]       bus_rdata_o
);
    logic              wr_ctrl, wr_prot, wr_clr;
    rsel_t             rsel;
    logic              en, open;
    logic [WORD_W-1:0] s_time, s_date;
    logic              flag, ovf;

    tsc_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
        .sel_i     (bus_sel_i),
        .wr_i      (bus_wr_i),
        .addr_i    (bus_addr_i),
        .secure_i  (bus_secure_i),
        .open_i    (open),
        .wr_ctrl_o (wr_ctrl),
        .wr_prot_o (wr_prot),
        .wr_clr_o  (wr_clr),
        .rsel_o    (rsel)
    );

    tsc_cfg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ctrl_i (wr_ctrl),
        .wr_prot_i (wr_prot),
        .wdata_i   (bus_wdata_i),
        .en_o      (en),
        .open_o    (open)
    );

    tsc_capture u_cap (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_i         (en),
        .tamper_i     (tamper_i),
        .time_i       (live_time_i),
        .date_i       (live_date_i),
        .clr_wr_i     (wr_clr),
        .clr_data_i   (bus_wdata_i),
        .stamp_time_o (s_time),
        .stamp_date_o (s_date),
        .flag_o       (flag),
        .ovf_o        (ovf)
    );

    always_comb begin
        bus_rdata_o = '0;
        case (rsel)
            RS_CTRL: bus_rdata_o[CTRL_EN_BIT]   = en;
            RS_PROT: bus_rdata_o[PROT_OPEN_BIT] = open;
            RS_TIME: bus_rdata_o                = s_time;
            RS_DATE: bus_rdata_o                = s_date;
            RS_STAT: begin
                bus_rdata_o[ST_FLAG_BIT] = flag;
                bus_rdata_o[ST_OVF_BIT]  = ovf;
            end
            default: bus_rdata_o = '0;
        endcase
    end

    // R8: a locked non-secure read of the stamps shows nothing
    a_r8_locked_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel_i && !bus_wr_i && !bus_secure_i && !open &&
         (bus_addr_i == ADDR_W'(OFS_TIME) || bus_addr_i == ADDR_W'(OFS_DATE) ||
          bus_addr_i == ADDR_W'(OFS_STAT))) |-> (bus_rdata_o == '0));

    // R8: a locked non-secure clear changes no flag
    a_r8_locked_clear_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel_i && bus_wr_i && !bus_secure_i && !open && !tamper_i &&
         bus_addr_i == ADDR_W'(OFS_CLR)) |=> ($stable(flag) && $stable(ovf)));
endmodule

// File: tb/tsc_top_test.sv
module tsc_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [31:0]   live_time = '0;
    logic [31:0]   live_date = '0;
    logic          tamper = 1'b0;
    logic          sel = 1'b0;
    logic          wr = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic          sec = 1'b0;
    logic [31:0]   rdata;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tsc_top #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n),
        .live_time_i(live_time), .live_date_i(live_date), .tamper_i(tamper),
        .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_secure_i(sec), .bus_rdata_o(rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d,
                             input logic s, input logic pulse);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d; sec = s; tamper = pulse;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0; wdata = '0; tamper = 1'b0;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, input logic s, output logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b0; addr = a; sec = s;
        #1;
        d = rdata;
        sel = 1'b0;
    endtask

    task automatic pulse_once();
        @(negedge clk);
        tamper = 1'b1;
        @(negedge clk);
        tamper = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] t0, d0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_read(8'h18, 1'b1, v); check("R1 ctrl", v, 32'h0);
        bus_read(8'h20, 1'b1, v); check("R1 prot", v, 32'h0);
        bus_read(8'h30, 1'b1, v); check("R1 time", v, 32'h0);
        bus_read(8'h34, 1'b1, v); check("R1 date", v, 32'h0);
        bus_read(8'h50, 1'b1, v); check("R1 status", v, 32'h0);

        // R2 disabled capture
        live_time = 32'h0012_3456; live_date = 32'h0024_1231;
        pulse_once();
        bus_read(8'h50, 1'b1, v); check("R2 status", v, 32'h0);
        bus_read(8'h30, 1'b1, v); check("R2 time", v, 32'h0);

        bus_write(8'h18, 32'h0200_0000, 1'b1, 1'b0);
        bus_read(8'h18, 1'b1, v); check("R2 enable readback", v, 32'h0200_0000);

        // R3 R4 R5 R6 sweep over live values and clear patterns
        for (int k = 0; k < 8; k++) begin
            t0 = 32'hA500_0000 + k * 32'h0001_0203 + 32'h0012_3456;
            d0 = 32'hFF00_0000 ^ (k * 32'h0003_0507 + 32'h0024_12F1);
            live_time = t0; live_date = d0;
            pulse_once();
            live_time = ~t0; live_date = ~d0;
            bus_read(8'h50, 1'b1, v); check("R3 flag set", v, 32'h08);
            bus_read(8'h30, 1'b1, v); check("R3 time stamp", v, t0 & 32'h007F_7F7F);
            bus_read(8'h34, 1'b1, v); check("R4 date stamp", v, d0 & 32'h0000_FF3F);
            pulse_once();
            bus_read(8'h50, 1'b1, v); check("R5 overflow", v, 32'h18);
            bus_read(8'h30, 1'b1, v); check("R5 time kept", v, t0 & 32'h007F_7F7F);
            bus_read(8'h34, 1'b1, v); check("R5 date kept", v, d0 & 32'h0000_FF3F);
            bus_write(8'h5C, 32'h0, 1'b1, 1'b0);
            bus_read(8'h50, 1'b1, v); check("R6 zero clear", v, 32'h18);
            if (k[0]) begin
                bus_write(8'h5C, 32'h08, 1'b1, 1'b0);
                bus_read(8'h50, 1'b1, v); check("R6 clear flag only", v, 32'h10);
                bus_write(8'h5C, 32'h10, 1'b1, 1'b0);
            end else begin
                bus_write(8'h5C, 32'h10, 1'b1, 1'b0);
                bus_read(8'h50, 1'b1, v); check("R6 clear ovf only", v, 32'h08);
                bus_write(8'h5C, 32'h08, 1'b1, 1'b0);
            end
            bus_read(8'h50, 1'b1, v); check("R6 all clear", v, 32'h0);
        end

        // R7 event and clear in the same cycle, flag clear beforehand
        live_time = 32'h0015_2030; live_date = 32'h0000_1109;
        bus_write(8'h5C, 32'h18, 1'b1, 1'b1);
        bus_read(8'h50, 1'b1, v); check("R7 flag from clear state", v, 32'h08);
        bus_read(8'h30, 1'b1, v); check("R7 captured", v, 32'h0015_2030);
        // R7 with flag set beforehand
        bus_write(8'h5C, 32'h18, 1'b1, 1'b1);
        bus_read(8'h50, 1'b1, v); check("R7 flag from set state", v, 32'h18);

        // R8 locked non-secure access
        bus_read(8'h30, 1'b0, v); check("R8 ns time", v, 32'h0);
        bus_read(8'h34, 1'b0, v); check("R8 ns date", v, 32'h0);
        bus_read(8'h50, 1'b0, v); check("R8 ns status", v, 32'h0);
        bus_read(8'h18, 1'b0, v); check("R8 ns ctrl", v, 32'h0);
        bus_write(8'h5C, 32'h18, 1'b0, 1'b0);
        bus_read(8'h50, 1'b1, v); check("R8 ns clear ignored", v, 32'h18);
        bus_write(8'h18, 32'h0, 1'b0, 1'b0);
        bus_read(8'h18, 1'b1, v); check("R8 ns ctrl write ignored", v, 32'h0200_0000);

        // R9 protection word writable by secure only
        bus_write(8'h20, 32'h08, 1'b0, 1'b0);
        bus_read(8'h20, 1'b1, v); check("R9 ns prot write ignored", v, 32'h0);
        bus_write(8'h20, 32'h08, 1'b1, 1'b0);
        bus_read(8'h20, 1'b0, v); check("R9 prot open", v, 32'h08);
        bus_read(8'h50, 1'b0, v); check("R9 ns status visible", v, 32'h18);
        bus_read(8'h30, 1'b0, v); check("R9 ns time visible", v, 32'h0015_2030);
        bus_write(8'h5C, 32'h18, 1'b0, 1'b0);
        bus_read(8'h50, 1'b0, v); check("R9 ns clear works", v, 32'h0);

        // R10 unmapped offset
        bus_read(8'h44, 1'b1, v); check("R10 unmapped", v, 32'h0);
        bus_read(8'h5C, 1'b1, v); check("R10 clear reads zero", v, 32'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule